// File: doc/BRIEF.md
# Multi-Function Pin Controller

This block governs six general pins, each configured by its own one-byte settings word. The settings word picks what the pin does. It can be plain general-purpose I/O, an edge-watching alert input, a divided clock output, or an output whose value comes from a peripheral. The same word also holds the direction, the level driven when the pin is a GPIO output, pull-up and open-drain enables, and a two-bit auxiliary field. The auxiliary field is the edge selection on alert pins and the divide ratio on the clock pin. The block drives pad output, output-enable and pull-up controls. It takes the pad input levels and one drive bit per pin from the peripherals.

Two banks of settings are kept. The active bank controls the pins directly. The boot bank holds the values that the active bank should take. A reset initialises both banks. A load pulse copies the whole boot bank into the active bank in a single cycle. Software writes and reads either bank through a byte-indexed port. Alert pins synchronise their input, detect the selected edge and hold a sticky flag until a write-one-to-clear pulse removes it. The clock pin divides the block clock, which is taken to be the 12 MHz reference.

Top module: `iopin_ctrl`

## Requirements
- R1: A synchronous active-low reset loads every word of both banks with the INIT parameter (default 8'h10 for each pin) and clears all alert flags.
- R2: A write to the active bank (wr_bank=0) at index 0..5 changes that pin's pad controls from the clock edge that captures it. Settings byte layout: [1:0] function (00 GPIO, 01 alert, 10 clock, 11 peripheral), [2] direction (1 = output), [3] GPIO output level, [4] pull-up, [5] open-drain, [7:6] auxiliary.
- R3: A write to the boot bank (wr_bank=1) leaves the active bank and pads unchanged. A load_pu pulse copies all six boot words into the active bank at the next edge. When an active write coincides with a load, the load wins.
- R4: A GPIO output with open-drain off drives pad_oe=1 and pad_out equal to bit [3].
- R5: With open-drain on, a GPIO output or a peripheral-driven pin has pad_out=0, and pad_oe is the inverse of the data bit. The clock function ignores the open-drain bit.
- R6: pad_pu follows bit [4] only for a GPIO input or an alert pin. It is 0 for every output function.
- R7: The peripheral function (11) takes its data from periph_drv for that pin instead of bit [3].
- R8: On alert pins (IO0, IO2, IO4, IO5), the input passes two synchroniser flops and then the edge selected by [7:6] sets the flag: 00 none, 01 rising, 10 falling, 11 both.
- R9: A flag stays set until a flag_clr pulse on its bit. A new edge in the same cycle as the clear keeps it set. Pins without alert capability never raise a flag.
- R10: On IO3 the clock function outputs a divided clock with period 2, 3, 6 or 12 cycles for [7:6] = 00, 01, 10, 11. The output is high for the first floor(N/2) counts. The count restarts at zero when the function is entered or the ratio changes.
- R11: A function the pin does not support leaves the pin undriven with no pull-up. This covers alert on IO1 or IO3, and clock on any pin but IO3.
- R12: Writes at index 6 or 7 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider reference |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Settings write strobe |
| wr_bank | input | 1 | Write target: 0 active, 1 boot |
| wr_idx | input | 3 | Write byte index |
| wr_data | input | 8 | Write data |
| load_pu | input | 1 | Copy boot bank into active bank |
| rd_bank | input | 1 | Read source: 0 active, 1 boot |
| rd_idx | input | 3 | Read byte index |
| rd_data | output | 8 | Read data (combinational) |
| flag_clr | input | 6 | Write-one-to-clear for alert flags |
| pad_in | input | 6 | Pad input levels |
| periph_drv | input | 6 | Peripheral data per pin |
| pad_out | output | 6 | Pad output data |
| pad_oe | output | 6 | Pad output enable |
| pad_pu | output | 6 | Pad pull-up enable |
| alert_flag | output | 6 | Sticky alert flags |

## Verification
The hardest case to reach is an alert edge that arrives at the synchroniser output in exactly the cycle a clear pulse lands. The same goes for an active-bank write that coincides with a load pulse. Directed stimulus covers the load collision and each edge mode with settled inputs. A long seeded random phase then toggles pad inputs, clear bits, loads and writes every cycle, so that these collisions occur many times. A behavioural model of both banks, the three-stage input pipeline and the divider count is compared with every output at every falling clock edge.

// File: rtl/iopin_pkg.sv
// Shared types for the multi-function pin controller.
// Assumes a one-byte settings word per pin, laid out as in cfg_t.
package iopin_pkg;

    typedef enum logic [1:0] {
        FN_GPIO   = 2'b00,
        FN_ALERT  = 2'b01,
        FN_CLK    = 2'b10,
        FN_PERIPH = 2'b11
    } fn_e;

    // Edge selection codes held in the auxiliary field of an alert pin.
    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    typedef struct packed {
        logic [1:0] aux;   // edge select or divide ratio
        logic       od;    // open-drain enable
        logic       pu;    // pull-up enable
        logic       lvl;   // GPIO output level
        logic       dir;   // 1 = output
        fn_e        fn;    // pin function
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/iopin_regbank.sv
// Two banks of per-pin settings words: boot and active.
// Assumes one write port and one combinational read port. A load copies
// the boot bank into the active bank and takes priority over an active write.
module iopin_regbank
    import iopin_pkg::*;
#(
    parameter int                    NPINS = 6,
    parameter logic [NPINS*8-1:0]    INIT  = {NPINS{8'h10}},
    localparam int                   IDX_W = $clog2(NPINS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_bank,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 load_pu,
    input  logic                 rd_bank,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_data,
    output logic [NPINS*8-1:0]   act_flat,
    output logic [NPINS*8-1:0]   pu_flat
);

    logic [7:0] act_q [NPINS];
    logic [7:0] pu_q  [NPINS];

    for (genvar i = 0; i < NPINS; i++) begin : g_word
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(i));

        // Boot word: reset to INIT, updated only by boot-bank writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pu_q[i] <= INIT[i*8 +: 8];
            end else if (hit && wr_bank) begin
                pu_q[i] <= wr_data;
            end
        end

        // Active word: reset to INIT, load has priority over a direct write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q[i] <= INIT[i*8 +: 8];
            end else if (load_pu) begin
                act_q[i] <= pu_q[i];
            end else if (hit && !wr_bank) begin
                act_q[i] <= wr_data;
            end
        end

        assign act_flat[i*8 +: 8] = act_q[i];
        assign pu_flat[i*8 +: 8]  = pu_q[i];
    end

    // Read mux: an out-of-range index returns zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = rd_bank ? pu_q[i] : act_q[i];
            end
        end
    end

endmodule

// File: rtl/iopin_edge_det.sv
// Alert input path for one pin: two-flop synchroniser, an edge compare
// stage and a sticky flag. Assumes pin_in is asynchronous to clk.
// A new edge wins over a clear in the same cycle.
module iopin_edge_det
    import iopin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] edge_sel,
    input  logic       pin_in,
    input  logic       clr,
    output logic       flag
);

    logic meta_q, sync_q, prev_q;
    logic rise, fall, hit;

    // Synchroniser and previous-value stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;
    assign hit  = en & ((edge_sel[0] & rise) | (edge_sel[1] & fall));

    // Sticky flag: set by a selected edge, cleared by a one on clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= hit | (flag & ~clr);
        end
    end

endmodule

// File: rtl/iopin_clkdiv.sv
// Selectable integer clock divider for the clock-output pin.
// Assumes clk is the reference. The period is N cycles, with the output
// high for floor(N/2) of them. The count restarts when the ratio code
// changes and is held at zero while disabled.
module iopin_clkdiv #(
    parameter int  DIV0 = 2,
    parameter int  DIV1 = 3,
    parameter int  DIV2 = 6,
    parameter int  DIV3 = 12,
    localparam int CNT_W = $clog2(DIV3 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       clk_out
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio;
    logic [1:0]       sel_q;

    // Ratio lookup from the two-bit code.
    always_comb begin
        unique case (sel)
            2'b00:   ratio = CNT_W'(DIV0);
            2'b01:   ratio = CNT_W'(DIV1);
            2'b10:   ratio = CNT_W'(DIV2);
            default: ratio = CNT_W'(DIV3);
        endcase
    end

    // Counter with restart on disable or ratio change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= 2'b00;
        end else begin
            sel_q <= sel;
            if (!en || (sel != sel_q)) begin
                cnt_q <= '0;
            end else if (cnt_q == ratio - CNT_W'(1)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign clk_out = en && (cnt_q < (ratio >> 1));

endmodule

// File: rtl/iopin_pad_mux.sv
// Per-pin function mux. It turns one settings word into pad out, enable
// and pull controls. ALERT_OK and CLK_OK state which optional functions
// this pin supports. An unsupported function leaves the pin undriven.
module iopin_pad_mux
    import iopin_pkg::*;
#(
    parameter bit ALERT_OK = 1'b0,
    parameter bit CLK_OK   = 1'b0
) (
    input  cfg_t cfg,
    input  logic periph,
    input  logic clk_in,
    output logic out,
    output logic oe,
    output logic pu,
    output logic alert_en,
    output logic clk_en
);

    // Function decode into pad controls.
    always_comb begin
        out      = 1'b0;
        oe       = 1'b0;
        pu       = 1'b0;
        alert_en = 1'b0;
        clk_en   = 1'b0;
        unique case (cfg.fn)
            FN_GPIO: begin
                if (cfg.dir) begin
                    if (cfg.od) begin
                        oe = ~cfg.lvl;
                    end else begin
                        oe  = 1'b1;
                        out = cfg.lvl;
                    end
                end else begin
                    pu = cfg.pu;
                end
            end
            FN_ALERT: begin
                if (ALERT_OK) begin
                    pu       = cfg.pu;
                    alert_en = 1'b1;
                end
            end
            FN_CLK: begin
                if (CLK_OK) begin
                    oe     = 1'b1;
                    out    = clk_in;
                    clk_en = 1'b1;
                end
            end
            default: begin
                if (cfg.od) begin
                    oe = ~periph;
                end else begin
                    oe  = 1'b1;
                    out = periph;
                end
            end
        endcase
    end

endmodule

// File: rtl/iopin_ctrl.sv
// Top of the multi-function pin controller. It ties together the settings
// banks, one function mux per pin, the alert paths on capable pins and the
// single clock divider. The pin capabilities come from ALERT_MASK and
// CLK_PIN.
module iopin_ctrl
    import iopin_pkg::*;
#(
    parameter int                 NPINS      = 6,
    parameter logic [NPINS-1:0]   ALERT_MASK = 6'b110101,
    parameter int                 CLK_PIN    = 3,
    parameter logic [NPINS*8-1:0] INIT       = {NPINS{8'h10}},
    localparam int                IDX_W      = $clog2(NPINS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             load_pu,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic [NPINS-1:0] flag_clr,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] periph_drv,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] alert_flag
);

    logic [NPINS*8-1:0] act_flat;
    logic [NPINS*8-1:0] pu_flat;
    logic [NPINS-1:0]   alert_en;
    logic [NPINS-1:0]   clk_en;
    logic               div_out;
    cfg_t               clk_cfg;

    iopin_regbank #(
        .NPINS (NPINS),
        .INIT  (INIT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .load_pu  (load_pu),
        .rd_bank  (rd_bank),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .act_flat (act_flat),
        .pu_flat  (pu_flat)
    );

    assign clk_cfg = cfg_t'(act_flat[CLK_PIN*8 +: 8]);

    iopin_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_en[CLK_PIN]),
        .sel     (clk_cfg.aux),
        .clk_out (div_out)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        cfg_t cfg;
        assign cfg = cfg_t'(act_flat[i*8 +: 8]);

        iopin_pad_mux #(
            .ALERT_OK (ALERT_MASK[i]),
            .CLK_OK   (i == CLK_PIN)
        ) u_mux (
            .cfg      (cfg),
            .periph   (periph_drv[i]),
            .clk_in   ((i == CLK_PIN) ? div_out : 1'b0),
            .out      (pad_out[i]),
            .oe       (pad_oe[i]),
            .pu       (pad_pu[i]),
            .alert_en (alert_en[i]),
            .clk_en   (clk_en[i])
        );

        if (ALERT_MASK[i]) begin : g_alert
            iopin_edge_det u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (alert_en[i]),
                .edge_sel (cfg.aux),
                .pin_in   (pad_in[i]),
                .clr      (flag_clr[i]),
                .flag     (alert_flag[i])
            );
        end else begin : g_no_alert
            assign alert_flag[i] = 1'b0;
        end
    end

endmodule

// File: rtl/iopin_ctrl_chk.sv
// Property checker for iopin_ctrl, attached by bind. Reads the ports and
// the two bank vectors of the top module.
module iopin_ctrl_chk #(
    parameter int  NPINS = 6,
    localparam int IDX_W = $clog2(NPINS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               load_pu,
    input logic [NPINS*8-1:0] act_flat,
    input logic [NPINS*8-1:0] pu_flat,
    input logic [NPINS-1:0]   pad_out,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   pad_pu,
    input logic [NPINS-1:0]   alert_flag,
    input logic [NPINS-1:0]   flag_clr
);

    // R3: the active bank equals the old boot bank after a load.
    p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_pu |=> (act_flat == $past(pu_flat)));

    // R12: out-of-range writes leave both banks untouched.
    p_bad_idx_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx >= IDX_W'(NPINS)) && !load_pu)
        |=> ($stable(act_flat) && $stable(pu_flat)));

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
        logic od_mode;
        assign od_mode = act_flat[i*8+5] &&
                         ((act_flat[i*8 +: 2] == 2'b00 && act_flat[i*8+2]) ||
                          (act_flat[i*8 +: 2] == 2'b11));

        // R5: an open-drain pin never drives high.
        p_od_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            od_mode |-> !(pad_oe[i] && pad_out[i]));

        // R6: pull-up is never on while the pin drives.
        p_pull_not_driving_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> !pad_pu[i]);

        // R9: a flag without a clear stays set.
        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (alert_flag[i] && !flag_clr[i]) |=> alert_flag[i]);
    end

endmodule

bind iopin_ctrl iopin_ctrl_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/iopin_ctrl_tb.sv
// Self-checking bench: a behavioural model updated on every rising edge
// and compared with all outputs on every falling edge, plus directed checks.
module iopin_ctrl_tb;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_bank = 1'b0, load_pu = 1'b0, rd_bank = 1'b0;
    logic [2:0]    wr_idx = '0, rd_idx = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic [NP-1:0] flag_clr = '0, pad_in = '1, periph_drv = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu, alert_flag;

    always #5 clk = ~clk;

    iopin_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_idx(wr_idx), .wr_data(wr_data), .load_pu(load_pu),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
        .flag_clr(flag_clr), .pad_in(pad_in), .periph_drv(periph_drv),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .alert_flag(alert_flag)
    );

    int    checks = 0, errors = 0;
    string phase = "R1";
    bit    finished = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0]    m_act [NP];
    logic [7:0]    m_pu  [NP];
    bit   [NP-1:0] m_s1, m_s2, m_s3, m_flag;
    int            m_cnt;
    logic [1:0]    m_selp;
    bit            m_valid = 1'b0;

    function automatic int ratio_of(logic [1:0] s);
        case (s)
            2'b00:   return 2;
            2'b01:   return 3;
            2'b10:   return 6;
            default: return 12;
        endcase
    endfunction

    function automatic bit can_alert(int i);
        return (i == 0) || (i == 2) || (i == 4) || (i == 5);
    endfunction

    always @(posedge clk) begin
        logic [7:0]    na [NP];
        logic [7:0]    np [NP];
        bit   [NP-1:0] nflag;
        bit            hit, en;
        logic [1:0]    sel;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_act[i] = 8'h10;
                m_pu[i]  = 8'h10;
            end
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_flag = '0;
            m_cnt = 0; m_selp = 2'b00;
            m_valid = 1'b1;
        end else begin
            for (int i = 0; i < NP; i++) begin
                np[i] = m_pu[i];
                na[i] = m_act[i];
                if (wr_en && wr_idx == 3'(i)) begin
                    if (wr_bank) np[i] = wr_data;
                    else         na[i] = wr_data;
                end
                if (load_pu) na[i] = m_pu[i];
                hit = 1'b0;
                if (can_alert(i) && m_act[i][1:0] == 2'b01) begin
                    if (m_act[i][6] && m_s2[i] && !m_s3[i]) hit = 1'b1;
                    if (m_act[i][7] && !m_s2[i] && m_s3[i]) hit = 1'b1;
                end
                nflag[i] = hit || (m_flag[i] && !flag_clr[i]);
            end
            en  = (m_act[3][1:0] == 2'b10);
            sel = m_act[3][7:6];
            if (!en || sel != m_selp) m_cnt = 0;
            else                      m_cnt = (m_cnt + 1) % ratio_of(sel);
            m_selp = sel;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            m_flag = nflag;
            for (int i = 0; i < NP; i++) begin
                m_act[i] = na[i];
                m_pu[i]  = np[i];
            end
        end
    end

    // Compare every output with the model away from the rising edge.
    always @(negedge clk) begin
        logic [NP-1:0] eo, eoe, epu;
        logic [7:0]    c, erd;
        if (m_valid && !finished) begin
            for (int i = 0; i < NP; i++) begin
                c = m_act[i];
                eo[i] = 1'b0; eoe[i] = 1'b0; epu[i] = 1'b0;
                case (c[1:0])
                    2'b00: begin
                        if (c[2]) begin
                            if (c[5]) eoe[i] = !c[3];
                            else begin eoe[i] = 1'b1; eo[i] = c[3]; end
                        end else epu[i] = c[4];
                    end
                    2'b01: if (can_alert(i)) epu[i] = c[4];
                    2'b10: if (i == 3) begin
                        eoe[i] = 1'b1;
                        eo[i]  = (m_cnt < ratio_of(c[7:6]) / 2);
                    end
                    default: begin
                        if (c[5]) eoe[i] = !periph_drv[i];
                        else begin eoe[i] = 1'b1; eo[i] = periph_drv[i]; end
                    end
                endcase
            end
            erd = (rd_idx < 3'd6) ? (rd_bank ? m_pu[rd_idx] : m_act[rd_idx]) : 8'h00;
            chk({phase, " pad_out"},    32'(pad_out),    32'(eo));
            chk({phase, " pad_oe"},     32'(pad_oe),     32'(eoe));
            chk({phase, " pad_pu"},     32'(pad_pu),     32'(epu));
            chk({phase, " alert_flag"}, 32'(alert_flag), 32'(m_flag));
            chk({phase, " rd_data"},    32'(rd_data),    32'(erd));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(bit bank, int idx, logic [7:0] d);
        wr_en = 1'b1; wr_bank = bank; wr_idx = 3'(idx); wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic clr_pulse(int i);
        flag_clr[i] = 1'b1;
        cyc(1);
        flag_clr[i] = 1'b0;
    endtask

    task automatic clk_measure(logic [7:0] cfg, int exp_hi, int exp_rise, string tag);
        int hi = 0, rises = 0;
        logic prev;
        wr(0, 3, cfg);
        cyc(2);
        @(negedge clk) prev = pad_out[3];
        if (prev) hi++;
        for (int k = 1; k < 25; k++) begin
            @(negedge clk);
            if (k < 24 && pad_out[3]) hi++;
            if (pad_out[3] && !prev) rises++;
            prev = pad_out[3];
        end
        chk({tag, " high count"}, 32'(hi), 32'(exp_hi));
        chk({tag, " rise count"}, 32'(rises), 32'(exp_rise));
        cyc(1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [NP-1:0] sv_oe, sv_out;
        cyc(3);
        rst_n = 1'b1;
        // R1: reset contents of both banks, flags cleared
        phase = "R1";
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < NP; i++) begin
                rd_bank = b[0]; rd_idx = 3'(i);
                @(negedge clk) chk("R1 reset word", 32'(rd_data), 32'h10);
                cyc(1);
            end
        end
        rd_bank = 1'b0; rd_idx = 3'd0;
        @(negedge clk);
        chk("R1 flags", 32'(alert_flag), 0);
        chk("R1 pulls", 32'(pad_pu), 32'h3F);
        cyc(1);

        // R2/R4: active write, push-pull GPIO output
        phase = "R4";
        wr(0, 0, 8'h0C);
        @(negedge clk) chk("R2 oe after write", 32'(pad_oe[0]), 1);
        chk("R4 out high", 32'(pad_out[0]), 1);
        cyc(1);
        wr(0, 0, 8'h04);
        @(negedge clk) chk("R4 out low", 32'(pad_out[0]), 0);
        cyc(1);

        // R5: open-drain GPIO
        phase = "R5";
        wr(0, 1, 8'h24);
        @(negedge clk) chk("R5 od low drives", 32'({pad_oe[1], pad_out[1]}), 32'b10);
        cyc(1);
        wr(0, 1, 8'h2C);
        @(negedge clk) chk("R5 od high released", 32'({pad_oe[1], pad_out[1]}), 32'b00);
        cyc(1);

        // R6: pull-up only on inputs
        phase = "R6";
        wr(0, 2, 8'h14);
        @(negedge clk) chk("R6 no pull on output", 32'(pad_pu[2]), 0);
        cyc(1);
        wr(0, 2, 8'h10);
        @(negedge clk) chk("R6 pull on input", 32'({pad_pu[2], pad_oe[2]}), 32'b10);
        cyc(1);

        // R7: peripheral-driven output, push-pull and open-drain
        phase = "R7";
        wr(0, 4, 8'h03);
        periph_drv[4] = 1'b1;
        @(negedge clk) chk("R7 periph high", 32'({pad_oe[4], pad_out[4]}), 32'b11);
        cyc(1);
        periph_drv[4] = 1'b0;
        @(negedge clk) chk("R7 periph low", 32'({pad_oe[4], pad_out[4]}), 32'b10);
        cyc(1);
        wr(0, 4, 8'h23);
        periph_drv[4] = 1'b1;
        @(negedge clk) chk("R5 periph od released", 32'(pad_oe[4]), 0);
        cyc(1);
        periph_drv[4] = 1'b0;
        @(negedge clk) chk("R5 periph od low", 32'({pad_oe[4], pad_out[4]}), 32'b10);
        cyc(1);

        // R8/R9: edge modes on IO0
        phase = "R8";
        wr(0, 0, 8'h51);
        cyc(4);
        pad_in[0] = 1'b0; cyc(5);
        @(negedge clk) chk("R8 rising mode ignores fall", 32'(alert_flag[0]), 0);
        cyc(1);
        pad_in[0] = 1'b1; cyc(5);
        @(negedge clk) chk("R8 rising edge sets flag", 32'(alert_flag[0]), 1);
        cyc(3);
        @(negedge clk) chk("R9 flag sticky", 32'(alert_flag[0]), 1);
        cyc(1);
        clr_pulse(0);
        @(negedge clk) chk("R9 clear", 32'(alert_flag[0]), 0);
        cyc(1);
        wr(0, 0, 8'h91);
        pad_in[0] = 1'b0; cyc(5);
        @(negedge clk) chk("R8 falling edge", 32'(alert_flag[0]), 1);
        cyc(1);
        clr_pulse(0);
        pad_in[0] = 1'b1; cyc(5);
        @(negedge clk) chk("R8 falling mode ignores rise", 32'(alert_flag[0]), 0);
        cyc(1);
        wr(0, 0, 8'hD1);
        pad_in[0] = 1'b0; cyc(5);
        @(negedge clk) chk("R8 both fall", 32'(alert_flag[0]), 1);
        cyc(1);
        clr_pulse(0);
        pad_in[0] = 1'b1; cyc(5);
        @(negedge clk) chk("R8 both rise", 32'(alert_flag[0]), 1);
        cyc(1);
        clr_pulse(0);
        wr(0, 0, 8'h11);
        pad_in[0] = 1'b0; cyc(5);
        pad_in[0] = 1'b1; cyc(5);
        @(negedge clk) chk("R8 none mode", 32'(alert_flag[0]), 0);
        cyc(1);

        // R9/R11: alert on a pin that lacks it
        phase = "R11";
        wr(0, 1, 8'hD1);
        pad_in[1] = 1'b0; cyc(5);
        pad_in[1] = 1'b1; cyc(5);
        @(negedge clk) chk("R9 no flag on IO1", 32'(alert_flag[1]), 0);
        chk("R11 IO1 alert undriven no pull", 32'({pad_oe[1], pad_pu[1]}), 0);
        cyc(1);
        wr(0, 0, 8'h02);
        @(negedge clk) chk("R11 clock on IO0 undriven", 32'(pad_oe[0]), 0);
        cyc(1);

        // R10: divider ratios
        phase = "R10";
        clk_measure(8'h82, 12, 4, "R10 div6");
        clk_measure(8'h42, 8, 8, "R10 div3");
        clk_measure(8'hC2, 12, 2, "R10 div12");
        clk_measure(8'h02, 12, 12, "R10 div2");

        // R3: boot bank and load
        phase = "R3";
        wr(1, 5, 8'h0C);
        rd_bank = 1'b0; rd_idx = 3'd5;
        @(negedge clk) chk("R3 active untouched", 32'(rd_data), 32'h10);
        chk("R3 pad untouched", 32'(pad_oe[5]), 0);
        cyc(1);
        load_pu = 1'b1; cyc(1); load_pu = 1'b0;
        @(negedge clk) chk("R3 load applies", 32'({pad_oe[5], pad_out[5]}), 32'b11);
        cyc(1);
        wr(1, 5, 8'h24);
        load_pu = 1'b1;
        wr(0, 5, 8'h03);
        load_pu = 1'b0;
        @(negedge clk) chk("R3 load beats write", 32'(rd_data), 32'h24);
        cyc(1);

        // R12: out-of-range index
        phase = "R12";
        @(negedge clk) begin sv_oe = pad_oe; sv_out = pad_out; end
        cyc(1);
        wr(0, 6, 8'hFF);
        wr(1, 7, 8'hFF);
        rd_idx = 3'd6; rd_bank = 1'b0;
        @(negedge clk) chk("R12 read idx6", 32'(rd_data), 0);
        chk("R12 pads unchanged", 32'({pad_oe, pad_out}), 32'({sv_oe, sv_out}));
        cyc(1);
        rd_idx = 3'd7; rd_bank = 1'b1;
        @(negedge clk) chk("R12 read idx7", 32'(rd_data), 0);
        cyc(1);

        // R2: mixed seeded random traffic against the model
        phase = "R2";
        void'($urandom(32'd7));
        for (int n = 0; n < 4000; n++) begin
            wr_en      = ($urandom % 4) == 0;
            wr_bank    = $urandom % 2;
            wr_idx     = 3'($urandom % 8);
            wr_data    = 8'($urandom);
            load_pu    = ($urandom % 32) == 0;
            rd_bank    = $urandom % 2;
            rd_idx     = 3'($urandom % 8);
            flag_clr   = (($urandom % 6) == 0) ? 6'($urandom) : '0;
            pad_in     = pad_in ^ (6'($urandom) & 6'($urandom));
            periph_drv = 6'($urandom);
            cyc(1);
        end
        wr_en = 1'b0; load_pu = 1'b0; flag_clr = '0;
        cyc(2);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule